// File: doc/BRIEF.md
# Timer Status Flag Unit

This block pairs a 16-bit free-running counter with an event status register. Five events are tracked: an edge on either of two capture pins, a match between the counter and either of two compare registers, and the counter wrapping from its all-ones value back to zero. Each event sets a sticky flag. Three interrupt outputs, one per event class, are raised while a flag of that class is set and its enable bit in the control register is on.

Software sees the unit through a byte-wide register bus. A flag is cleared only by a two-step sequence. The first step is a read or write of the status register while the flag is set, which arms the flag. The second step is a read of the low byte of the register that belongs to that flag. A second counter window, the alias counter, returns the same count, but reading it never clears the overflow flag. This lets software time intervals without losing a pending overflow. Reading a high byte holds the matching low byte, so a 16-bit value read high then low is coherent.

The bus has no back-pressure. A read returns data combinationally in the cycle `bus_rd` is high, and any side effect (arming, clearing, holding) happens at the clock edge that ends that cycle. The capture pins are expected to be synchronous to `clk`.

Top module: `tsf_timer_status`

## Requirements
- R1: After reset the counter is 0xFFFC, the control register and all flags are zero, and all three interrupt outputs are low.
- R2: Registers sit at `BASE` plus these offsets: 0x2 control, 0x3 status, 0x4/0x5 capture 1 high/low, 0x6/0x7 compare 1 high/low, 0x8/0x9 counter high/low, 0xA/0xB alias counter high/low, 0xC/0xD capture 2 high/low, 0xE/0xF compare 2 high/low. The status register is read-only. Its bits are: 7 capture 1, 6 compare 1, 5 overflow, 4 capture 2, 3 compare 2. Bits 2..0 read as zero. A read with `bus_rd` low, or outside the window, returns 0.
- R3: The counter advances by one every clock. The overflow flag sets on the edge where the counter goes from 0xFFFF to 0x0000.
- R4: A compare flag sets on the edge where its compare register equals the counter value.
- R5: Control bit 0 (capture 1) and bit 1 (capture 2) select the active edge: 1 means rising, 0 means falling. On the active edge the flag sets and the capture register loads the counter value present at that edge. An edge of the other polarity has no effect.
- R6: A flag is cleared by a status access while the flag is set, followed by a read of its low byte register. The low byte registers are capture low, compare low, and counter low (0x9) for overflow. A low byte read without that earlier access leaves the flag set.
- R7: A write to the status register arms the set flags in the same way a read does.
- R8: If a flag's event occurs in the same cycle as its clearing read, the flag stays set.
- R9: Reading the alias counter low byte never clears the overflow flag.
- R10: Reading a counter or capture high byte holds that register's low byte. The next read of the low byte returns the held value.
- R11: The control register enable bits gate the interrupt outputs. Bit 7 gates `irq_capture`, which is high when either capture flag is set. Bit 6 gates `irq_compare`, which is high when either compare flag is set. Bit 5 gates `irq_overflow`, which follows the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| cap_pin | input | 2 | Capture inputs, bit 0 is channel 1 |
| irq_capture | output | 1 | Capture interrupt |
| irq_compare | output | 1 | Compare interrupt |
| irq_overflow | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with its default parameters: a base of 0x10 and a counter reset value of 0xFFFC. The reset value of 0xFFFC places the first overflow and the first compare match (compare registers reset to zero) only a few cycles after reset, so the arming and clearing rules can be checked early. A second wrap, about 65,536 cycles later, then allows the overflow flag to be checked against the alias counter. A behavioural model runs alongside the unit and is compared on every clock. Scripted sequences add the lone low byte read, arming by a status write, a capture edge that lands on the clearing read, and the held low byte after a high byte read.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int TW = 16;
  localparam int NFLG = 5;
  // register offsets inside the 16-byte window
  localparam logic [3:0] OFS_CTRL  = 4'h2;
  localparam logic [3:0] OFS_STAT  = 4'h3;
  localparam logic [3:0] OFS_CAP1H = 4'h4;
  localparam logic [3:0] OFS_CAP1L = 4'h5;
  localparam logic [3:0] OFS_CMP1H = 4'h6;
  localparam logic [3:0] OFS_CMP1L = 4'h7;
  localparam logic [3:0] OFS_CNTH  = 4'h8;
  localparam logic [3:0] OFS_CNTL  = 4'h9;
  localparam logic [3:0] OFS_ALTH  = 4'hA;
  localparam logic [3:0] OFS_ALTL  = 4'hB;
  localparam logic [3:0] OFS_CAP2H = 4'hC;
  localparam logic [3:0] OFS_CAP2L = 4'hD;
  localparam logic [3:0] OFS_CMP2H = 4'hE;
  localparam logic [3:0] OFS_CMP2L = 4'hF;
  // flag vector index; the status byte is {flags, 3'b000}
  localparam int F_IC1 = 4;
  localparam int F_OC1 = 3;
  localparam int F_TOV = 2;
  localparam int F_IC2 = 1;
  localparam int F_OC2 = 0;
endpackage

// File: rtl/tsf_counter.sv
module tsf_counter
  import tsf_pkg::*;
#(
  parameter logic [TW-1:0] RST_VAL = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] cnt,
  output logic          wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= RST_VAL;
    else        cnt <= cnt + 1'b1;
  end

  assign wrap = &cnt;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/tsf_capture.sv
module tsf_capture
  import tsf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          rising,
  input  logic [TW-1:0] cnt,
  output logic          evt,
  output logic [TW-1:0] cap
);
  logic prev_q;

  assign evt = (pin != prev_q) && (pin == rising);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap    <= '0;
    end else begin
      prev_q <= pin;
      if (evt) cap <= cnt;
    end
  end

  assert_cap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap == $past(cnt));
endmodule

// File: rtl/tsf_flags.sv
module tsf_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         stat_acc,
  input  logic [N-1:0] lo_rd,
  output logic [N-1:0] flag
);
  logic [N-1:0] arm_q, flag_d, arm_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      flag_d[i] = evt[i] | (flag[i] & ~(arm_q[i] & lo_rd[i]));
      arm_d[i]  = flag_d[i] & ((stat_acc & flag[i]) | (arm_q[i] & ~lo_rd[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= '0;
      arm_q <= '0;
    end else begin
      flag  <= flag_d;
      arm_q <= arm_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_keep_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !arm_q[g]) |=> flag[g]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flag[g]);
  end
endmodule

// File: rtl/tsf_timer_status.sv
module tsf_timer_status
  import tsf_pkg::*;
#(
  parameter logic [7:0]    BASE      = 8'h10,
  parameter logic [TW-1:0] CNT_RESET = 16'hFFFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] cap_pin,
  output logic       irq_capture,
  output logic       irq_compare,
  output logic       irq_overflow
);
  localparam int NCH = 2;
  localparam int NPAIR = 4;

  logic          sel;
  logic [3:0]    ofs;
  logic [TW-1:0] cnt;
  logic          wrap;
  logic [7:0]    ctrl_q;
  logic [TW-1:0] cmp_q [NCH];
  logic [TW-1:0] cap   [NCH];
  logic [NCH-1:0] cap_evt, cmp_hit;
  logic [NFLG-1:0] flags, evt, lo_rd;
  logic          stat_acc;
  logic [7:0]    lo_val [NPAIR];

  assign sel = bus_addr[7:4] == BASE[7:4];
  assign ofs = bus_addr[3:0];

  function automatic logic rd_at(input logic [3:0] o);
    return bus_rd && sel && (ofs == o);
  endfunction

  function automatic logic wr_at(input logic [3:0] o);
    return bus_wr && sel && (ofs == o);
  endfunction

  tsf_counter #(.RST_VAL(CNT_RESET)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [3:0] HO = (c == 0) ? OFS_CMP1H : OFS_CMP2H;
    localparam logic [3:0] LO = (c == 0) ? OFS_CMP1L : OFS_CMP2L;
    tsf_capture u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[c]), .rising(ctrl_q[c]),
      .cnt(cnt), .evt(cap_evt[c]), .cap(cap[c]));
    always_ff @(posedge clk) begin
      if (!rst_n) cmp_q[c] <= '0;
      else begin
        if (wr_at(HO)) cmp_q[c][15:8] <= bus_wdata;
        if (wr_at(LO)) cmp_q[c][7:0]  <= bus_wdata;
      end
    end
    assign cmp_hit[c] = cmp_q[c] == cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_at(OFS_CTRL)) ctrl_q <= bus_wdata;
  end

  // coherent high/low pairs: 0 capture 1, 1 counter, 2 alias, 3 capture 2
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam logic [3:0] HO = (p == 0) ? OFS_CAP1H : (p == 1) ? OFS_CNTH :
                                (p == 2) ? OFS_ALTH  : OFS_CAP2H;
    localparam logic [3:0] LO = HO + 4'd1;
    logic [TW-1:0] src;
    logic          held_q;
    logic [7:0]    buf_q;
    assign src = (p == 0) ? cap[0] : (p == 3) ? cap[1] : cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q <= 1'b0;
        buf_q  <= '0;
      end else if (rd_at(HO)) begin
        held_q <= 1'b1;
        buf_q  <= src[7:0];
      end else if (rd_at(LO)) begin
        held_q <= 1'b0;
      end
    end
    assign lo_val[p] = held_q ? buf_q : src[7:0];
  end

  assign stat_acc = sel && (ofs == OFS_STAT) && (bus_rd || bus_wr);

  always_comb begin
    evt = '0;
    evt[F_IC1] = cap_evt[0];
    evt[F_OC1] = cmp_hit[0];
    evt[F_TOV] = wrap;
    evt[F_IC2] = cap_evt[1];
    evt[F_OC2] = cmp_hit[1];
    lo_rd = '0;
    lo_rd[F_IC1] = rd_at(OFS_CAP1L);
    lo_rd[F_OC1] = rd_at(OFS_CMP1L);
    lo_rd[F_TOV] = rd_at(OFS_CNTL);
    lo_rd[F_IC2] = rd_at(OFS_CAP2L);
    lo_rd[F_OC2] = rd_at(OFS_CMP2L);
  end

  tsf_flags #(.N(NFLG)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .stat_acc(stat_acc),
    .lo_rd(lo_rd), .flag(flags));

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && sel) begin
      case (ofs)
        OFS_CTRL:  bus_rdata = ctrl_q;
        OFS_STAT:  bus_rdata = {flags, 3'b000};
        OFS_CAP1H: bus_rdata = cap[0][15:8];
        OFS_CAP1L: bus_rdata = lo_val[0];
        OFS_CMP1H: bus_rdata = cmp_q[0][15:8];
        OFS_CMP1L: bus_rdata = cmp_q[0][7:0];
        OFS_CNTH:  bus_rdata = cnt[15:8];
        OFS_CNTL:  bus_rdata = lo_val[1];
        OFS_ALTH:  bus_rdata = cnt[15:8];
        OFS_ALTL:  bus_rdata = lo_val[2];
        OFS_CAP2H: bus_rdata = cap[1][15:8];
        OFS_CAP2L: bus_rdata = lo_val[3];
        OFS_CMP2H: bus_rdata = cmp_q[1][15:8];
        OFS_CMP2L: bus_rdata = cmp_q[1][7:0];
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq_capture  = ctrl_q[7] & (flags[F_IC1] | flags[F_IC2]);
  assign irq_compare  = ctrl_q[6] & (flags[F_OC1] | flags[F_OC2]);
  assign irq_overflow = ctrl_q[5] & flags[F_TOV];

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |=> flags[F_TOV]);
  assert_alt_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_at(OFS_ALTL) && flags[F_TOV]) |=> flags[F_TOV]);
  assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q[0] == cnt) |=> flags[F_OC1]);
endmodule

// File: tb/tsf_timer_status_test.sv
module tsf_timer_status_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cap_pin = '0;
  logic       irq_capture, irq_compare, irq_overflow;

  int errors = 0;
  int checks = 0;
  logic [7:0] last_rd;

  // behavioural model state
  int m_cnt;
  bit m_flag[5];   // 4 ic1, 3 oc1, 2 tov, 1 ic2, 0 oc2
  bit m_arm[5];
  int m_cap[2];
  int m_cmp[2];
  int m_ctrl;
  bit m_held[4];
  int m_buf[4];
  bit m_prev[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsf_timer_status uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .irq_capture(irq_capture), .irq_compare(irq_compare),
    .irq_overflow(irq_overflow));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pair_src(input int p);
    if (p == 0) return m_cap[0];
    if (p == 3) return m_cap[1];
    return m_cnt;
  endfunction

  function automatic int m_read(input logic [7:0] a, input logic r);
    int o;
    if (!r || a[7:4] != 4'h1) return 0;
    o = a[3:0];
    case (o)
      2:  return m_ctrl;
      3:  return (m_flag[4] << 7) | (m_flag[3] << 6) | (m_flag[2] << 5) |
                 (m_flag[1] << 4) | (m_flag[0] << 3);
      4:  return m_cap[0] >> 8;
      5:  return m_held[0] ? m_buf[0] : (m_cap[0] & 255);
      6:  return m_cmp[0] >> 8;
      7:  return m_cmp[0] & 255;
      8:  return m_cnt >> 8;
      9:  return m_held[1] ? m_buf[1] : (m_cnt & 255);
      10: return m_cnt >> 8;
      11: return m_held[2] ? m_buf[2] : (m_cnt & 255);
      12: return m_cap[1] >> 8;
      13: return m_held[3] ? m_buf[3] : (m_cap[1] & 255);
      14: return m_cmp[1] >> 8;
      15: return m_cmp[1] & 255;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 16'hFFFC; m_ctrl = 0;
    for (int i = 0; i < 5; i++) begin m_flag[i] = 0; m_arm[i] = 0; end
    for (int i = 0; i < 2; i++) begin m_cap[i] = 0; m_cmp[i] = 0; m_prev[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_held[i] = 0; m_buf[i] = 0; end
  endtask

  task automatic model_step();
    bit ev[5], lord[5], stat, here;
    int o, lo_of[5];
    bit cev[2];
    here = bus_addr[7:4] == 4'h1;
    o = bus_addr[3:0];
    lo_of = '{15, 13, 9, 7, 5};  // index 0 oc2 .. 4 ic1
    for (int k = 0; k < 2; k++) begin
      bit pol;
      pol = (m_ctrl >> k) & 1;
      cev[k] = (cap_pin[k] != m_prev[k]) && (cap_pin[k] == pol);
    end
    ev[4] = cev[0]; ev[3] = (m_cmp[0] == m_cnt); ev[2] = (m_cnt == 16'hFFFF);
    ev[1] = cev[1]; ev[0] = (m_cmp[1] == m_cnt);
    stat = here && o == 3 && (bus_rd || bus_wr);
    for (int i = 0; i < 5; i++) begin
      bit nf, na;
      lord[i] = here && bus_rd && o == lo_of[i];
      nf = ev[i] || (m_flag[i] && !(m_arm[i] && lord[i]));
      na = nf && ((stat && m_flag[i]) || (m_arm[i] && !lord[i]));
      m_flag[i] = nf; m_arm[i] = na;
    end
    for (int p = 0; p < 4; p++) begin
      int ho;
      ho = (p == 0) ? 4 : (p == 1) ? 8 : (p == 2) ? 10 : 12;
      if (here && bus_rd && o == ho) begin
        m_held[p] = 1; m_buf[p] = pair_src(p) & 255;
      end else if (here && bus_rd && o == ho + 1) m_held[p] = 0;
    end
    for (int k = 0; k < 2; k++) begin
      if (cev[k]) m_cap[k] = m_cnt;
      m_prev[k] = cap_pin[k];
    end
    if (here && bus_wr) begin
      if (o == 2) m_ctrl = bus_wdata;
      if (o == 6) m_cmp[0] = (m_cmp[0] & 255) | (bus_wdata << 8);
      if (o == 7) m_cmp[0] = (m_cmp[0] & 16'hFF00) | bus_wdata;
      if (o == 14) m_cmp[1] = (m_cmp[1] & 255) | (bus_wdata << 8);
      if (o == 15) m_cmp[1] = (m_cmp[1] & 16'hFF00) | bus_wdata;
    end
    m_cnt = (m_cnt + 1) & 16'hFFFF;
  endtask

  // one bus cycle; outputs compared against the model before the edge
  task automatic cyc(input logic [7:0] a, input logic r, input logic w,
                     input logic [7:0] d);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    #1;
    last_rd = bus_rdata;
    chk("R2 rdata", bus_rdata, m_read(a, r));
    chk("R11 irq_capture", irq_capture,
        ((m_ctrl >> 7) & 1) & (m_flag[4] | m_flag[1]));
    chk("R11 irq_compare", irq_compare,
        ((m_ctrl >> 6) & 1) & (m_flag[3] | m_flag[0]));
    chk("R11 irq_overflow", irq_overflow, ((m_ctrl >> 5) & 1) & m_flag[2]);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(a, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(a, 1'b0, 1'b1, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, hv;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irqs", {irq_capture, irq_compare, irq_overflow}, 0);
    rd(8'h19); chk("R1 counter low", last_rd, 8'hFC);
    rd(8'h12); chk("R1 control", last_rd, 0);
    rd(8'h13); chk("R1 status", last_rd, 0);

    idle(6);
    rd(8'h13);
    chk("R3 overflow flag", last_rd[5], 1);
    chk("R4 compare flags", {last_rd[6], last_rd[3]}, 2'b11);
    rd(8'h19);
    rd(8'h13); chk("R6 overflow cleared", last_rd[5], 0);
    rd(8'h17); rd(8'h1F);
    rd(8'h13); chk("R6 compare cleared", {last_rd[6], last_rd[3]}, 0);

    // capture 1 rising, capture 2 falling
    wr(8'h12, 8'h01);
    cap_pin[0] = 1'b1; c0 = m_cnt; idle(1);
    rd(8'h14); hv = last_rd;
    rd(8'h15); chk("R5 capture value", (hv << 8) | last_rd, c0);
    wr(8'h12, 8'h81);
    chk("R6 lone low read keeps flag", irq_capture, 1);
    wr(8'h13, 8'hFF);
    rd(8'h15);
    rd(8'h13);
    chk("R7 status write arms", last_rd[7], 0);
    chk("R2 low status bits", last_rd[2:0], 0);
    chk("R11 capture irq low", irq_capture, 0);

    cap_pin[1] = 1'b1; idle(1);
    rd(8'h13); chk("R5 wrong edge ignored", last_rd[4], 0);
    cap_pin[1] = 1'b0; idle(1);
    rd(8'h13); chk("R5 falling edge flag", last_rd[4], 1);
    cap_pin[1] = 1'b1; idle(1);
    cap_pin[1] = 1'b0; rd(8'h1D);
    rd(8'h13); chk("R8 set wins over clear", last_rd[4], 1);

    c0 = m_cnt;
    rd(8'h18); chk("R10 high byte", last_rd, (c0 >> 8) & 255);
    idle(3);
    rd(8'h19); chk("R10 held low byte", last_rd, c0 & 255);

    while (m_cnt != 16'h0003) idle(1);
    rd(8'h13); chk("R3 second wrap", last_rd[5], 1);
    rd(8'h1B);
    wr(8'h12, 8'h20);
    chk("R9 alias read keeps overflow", irq_overflow, 1);
    rd(8'h19);
    chk("R6 overflow irq cleared", irq_overflow, 0);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule